// File: doc/BRIEF.md
# Operand Addressing Mode Decoder

This block turns one operand specifier of a 16-bit microcontroller instruction into a normalized operand descriptor. The instruction decoder presents a register number, a mode field (two bits for a source operand, one bit for a destination operand), an optional extension nibble, the instruction's address and the byte offset of the next unread instruction word. The block answers with the operand kind, the register involved, a 20-bit value or address, and whether an extra instruction word was consumed.

Some register and mode pairs do not mean plain register addressing: the constant-generator register and the status register yield hard-wired constants in some modes, the program counter yields symbolic (PC-relative) and immediate operands, and the status register in indexed mode gives absolute addressing. When the specifier needs an extra word, the block raises `need_word` and takes the word through a valid/ready handshake before it reports the result. Execution, memory access and register write-back belong elsewhere.

Top module: `opspec_decoder`

## Requirements
- R1: After reset `res_valid`, `need_word` and `word_ready` are 0.
- R2: A source with register 3 and mode 0, 1, 2 or 3 gives kind IMM (code 1) with value 0, 1, 2 or 0xFFFFF, register output 0, no word fetched, and `res_valid` in the cycle after `start`.
- R3: A source with register 2 gives IMM value 4 in mode 2 and IMM value 8 in mode 3, with no word; in mode 0 it gives kind REG (code 0) with register 2.
- R4: A destination with mode bit 0 (`mode[0]`; `mode[1]` is ignored for destinations) gives kind REG with the given register for every register number; a source in mode 0 with any register other than 3 also gives REG. The value output is 0 and no word is fetched.
- R5: Mode 1 with register 0, for source or destination, is symbolic: kind ABS (code 4), register 0, value = (operand word + `instr_addr` + `word_ofs`) modulo 2^20, where the operand word is the 20-bit form given in R9.
- R6: Mode 1 with register 2 is absolute: kind ABS, register 0, value = the 20-bit operand word.
- R7: Mode 1 with any register other than 0, 2 and 3 (destination: other than 0 and 2) is indexed: kind IND (code 2), register = base register, value = the 20-bit operand word as displacement.
- R8: Source mode 3 with register 0 is an immediate from the next word (IMM, value = 20-bit operand word). Mode 3 with registers 1 and 4..15 gives POSTINC (code 3) with value 0; mode 2 with registers 0, 1 and 4..15 gives IND with value 0; neither fetches a word.
- R9: The 20-bit operand word is {`ext_nibble`, `word_data`} when `ext_active` was high at `start`, otherwise {4'h0, `word_data`}.
- R10: For a specifier that needs a word, `need_word` and `word_ready` are high from the cycle after `start` until the cycle in which `word_valid` is seen with them; `res_valid` rises in the cycle after that, with `res_used_word` = 1. A `start` seen while waiting is ignored.
- R11: `res_valid` is a one-cycle pulse, and the result outputs stay unchanged until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Present a specifier for decoding |
| is_dst | input | 1 | 1 = destination specifier, 0 = source |
| mode | input | 2 | Mode field (destination uses bit 0 only) |
| reg_num | input | 4 | Register number of the specifier |
| ext_active | input | 1 | An extension prefix is in force |
| ext_nibble | input | 4 | Upper address bits from the extension prefix |
| instr_addr | input | 20 | Address of the current instruction |
| word_ofs | input | 20 | Byte offset of the next unread word from the instruction address |
| word_valid | input | 1 | Fetched word is present |
| word_data | input | 16 | Fetched word |
| word_ready | output | 1 | Block accepts the fetched word |
| need_word | output | 1 | An extra instruction word is required |
| res_valid | output | 1 | One-cycle pulse: result outputs are new |
| res_kind | output | 3 | 0 REG, 1 IMM, 2 IND, 3 POSTINC, 4 ABS |
| res_reg | output | 4 | Register of the operand (0 for IMM and ABS) |
| res_value | output | 20 | Constant, displacement or address |
| res_used_word | output | 1 | The result consumed an extra word |

## Verification
The hardest situation to reach from the ports is a word-carrying specifier whose request is disturbed while it waits: a second `start` with different fields arrives during the wait, and the word arrives after a variable delay. Directed sequences issue such a request, pulse `start` mid-wait and check the delivered result still belongs to the first request, while the random stream stretches the wait between zero and several cycles. The symbolic case is also driven near the top of the 20-bit space so that the address sum wraps.

// File: rtl/opd_pkg.sv
package opd_pkg;

    localparam int ADDR_W = 20;
    localparam int WORD_W = 16;
    localparam int REG_W  = 4;
    localparam int EXT_W  = ADDR_W - WORD_W;

    localparam logic [REG_W-1:0] REG_PC = 4'd0;
    localparam logic [REG_W-1:0] REG_SR = 4'd2;
    localparam logic [REG_W-1:0] REG_CG = 4'd3;

    typedef enum logic [2:0] {
        OPK_REG     = 3'd0,
        OPK_IMM     = 3'd1,
        OPK_IND     = 3'd2,
        OPK_POSTINC = 3'd3,
        OPK_ABS     = 3'd4
    } opk_e;

    typedef enum logic [1:0] {
        VSRC_CONST = 2'd0,
        VSRC_WORD  = 2'd1,
        VSRC_PCREL = 2'd2
    } vsrc_e;

    typedef struct packed {
        opk_e              kind;
        logic [REG_W-1:0]  rnum;
        vsrc_e             vsrc;
        logic [ADDR_W-1:0] cval;
    } opclass_t;

    function automatic opclass_t mk_class(opk_e k, logic [REG_W-1:0] r,
                                          vsrc_e s, logic [ADDR_W-1:0] v);
        opclass_t c;
        c.kind = k;
        c.rnum = r;
        c.vsrc = s;
        c.cval = v;
        return c;
    endfunction

    function automatic logic needs_fetch(opclass_t c);
        return c.vsrc != VSRC_CONST;
    endfunction

endpackage

// File: rtl/opd_mode_table.sv
module opd_mode_table
    import opd_pkg::*;
(
    input  logic             is_dst,
    input  logic [1:0]       mode,
    input  logic [REG_W-1:0] reg_num,
    output opclass_t         cls
);
    localparam logic [ADDR_W-1:0] ALL_ONES = {ADDR_W{1'b1}};

    opclass_t src_cls;
    opclass_t dst_cls;

    // Indexed family shared by source mode 1 and destination mode 1.
    function automatic opclass_t indexed_family(logic [REG_W-1:0] r);
        if (r == REG_PC)
            return mk_class(OPK_ABS, '0, VSRC_PCREL, '0);
        else if (r == REG_SR)
            return mk_class(OPK_ABS, '0, VSRC_WORD, '0);
        else
            return mk_class(OPK_IND, r, VSRC_WORD, '0);
    endfunction

    always_comb begin
        src_cls = mk_class(OPK_REG, reg_num, VSRC_CONST, '0);
        unique case (mode)
            2'd0: begin
                if (reg_num == REG_CG)
                    src_cls = mk_class(OPK_IMM, '0, VSRC_CONST, '0);
            end
            2'd1: begin
                if (reg_num == REG_CG)
                    src_cls = mk_class(OPK_IMM, '0, VSRC_CONST, ADDR_W'(1));
                else
                    src_cls = indexed_family(reg_num);
            end
            2'd2: begin
                if (reg_num == REG_SR)
                    src_cls = mk_class(OPK_IMM, '0, VSRC_CONST, ADDR_W'(4));
                else if (reg_num == REG_CG)
                    src_cls = mk_class(OPK_IMM, '0, VSRC_CONST, ADDR_W'(2));
                else
                    src_cls = mk_class(OPK_IND, reg_num, VSRC_CONST, '0);
            end
            default: begin
                if (reg_num == REG_PC)
                    src_cls = mk_class(OPK_IMM, '0, VSRC_WORD, '0);
                else if (reg_num == REG_SR)
                    src_cls = mk_class(OPK_IMM, '0, VSRC_CONST, ADDR_W'(8));
                else if (reg_num == REG_CG)
                    src_cls = mk_class(OPK_IMM, '0, VSRC_CONST, ALL_ONES);
                else
                    src_cls = mk_class(OPK_POSTINC, reg_num, VSRC_CONST, '0);
            end
        endcase
    end

    always_comb begin
        if (mode[0])
            dst_cls = indexed_family(reg_num);
        else
            dst_cls = mk_class(OPK_REG, reg_num, VSRC_CONST, '0);
    end

    assign cls = is_dst ? dst_cls : src_cls;

endmodule

// File: rtl/opd_value_form.sv
module opd_value_form
    import opd_pkg::*;
(
    input  vsrc_e             vsrc,
    input  logic [ADDR_W-1:0] cval,
    input  logic              ext_active,
    input  logic [EXT_W-1:0]  ext_nibble,
    input  logic [WORD_W-1:0] word,
    input  logic [ADDR_W-1:0] word_addr,
    output logic [ADDR_W-1:0] value
);
    logic [EXT_W-1:0]  upper;
    logic [ADDR_W-1:0] wide_word;

    assign upper     = ext_active ? ext_nibble : '0;
    assign wide_word = {upper, word};

    always_comb begin
        unique case (vsrc)
            VSRC_WORD:  value = wide_word;
            VSRC_PCREL: value = wide_word + word_addr;
            default:    value = cval;
        endcase
    end

endmodule

// File: rtl/opd_fetch_ctrl.sv
module opd_fetch_ctrl (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic wants_word,
    input  logic word_valid,
    output logic waiting,
    output logic accept,
    output logic take_word
);
    typedef enum logic {ST_IDLE, ST_WAIT} st_e;
    st_e st;

    assign waiting   = (st == ST_WAIT);
    assign accept    = start && !waiting;
    assign take_word = waiting && word_valid;

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= ST_IDLE;
        end else begin
            unique case (st)
                ST_IDLE: if (accept && wants_word) st <= ST_WAIT;
                default: if (take_word)            st <= ST_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/opspec_decoder.sv
module opspec_decoder
    import opd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic              is_dst,
    input  logic [1:0]        mode,
    input  logic [REG_W-1:0]  reg_num,
    input  logic              ext_active,
    input  logic [EXT_W-1:0]  ext_nibble,
    input  logic [ADDR_W-1:0] instr_addr,
    input  logic [ADDR_W-1:0] word_ofs,
    input  logic              word_valid,
    input  logic [WORD_W-1:0] word_data,
    output logic              word_ready,
    output logic              need_word,
    output logic              res_valid,
    output logic [2:0]        res_kind,
    output logic [REG_W-1:0]  res_reg,
    output logic [ADDR_W-1:0] res_value,
    output logic              res_used_word
);
    opclass_t          cur_cls;
    opclass_t          pend_cls;
    logic              pend_ext;
    logic [EXT_W-1:0]  pend_nib;
    logic [ADDR_W-1:0] pend_waddr;
    logic [ADDR_W-1:0] word_value;
    logic              cur_needs;
    logic              waiting;
    logic              accept;
    logic              take_word;

    opd_mode_table u_table (
        .is_dst  (is_dst),
        .mode    (mode),
        .reg_num (reg_num),
        .cls     (cur_cls)
    );

    assign cur_needs = needs_fetch(cur_cls);

    opd_fetch_ctrl u_ctrl (
        .clk        (clk),
        .rst        (rst),
        .start      (start),
        .wants_word (cur_needs),
        .word_valid (word_valid),
        .waiting    (waiting),
        .accept     (accept),
        .take_word  (take_word)
    );

    opd_value_form u_form (
        .vsrc       (pend_cls.vsrc),
        .cval       (pend_cls.cval),
        .ext_active (pend_ext),
        .ext_nibble (pend_nib),
        .word       (word_data),
        .word_addr  (pend_waddr),
        .value      (word_value)
    );

    assign need_word  = waiting;
    assign word_ready = waiting;

    // Request capture for the word path.
    always_ff @(posedge clk) begin
        if (rst) begin
            pend_cls   <= mk_class(OPK_REG, '0, VSRC_CONST, '0);
            pend_ext   <= 1'b0;
            pend_nib   <= '0;
            pend_waddr <= '0;
        end else if (accept && cur_needs) begin
            pend_cls   <= cur_cls;
            pend_ext   <= ext_active;
            pend_nib   <= ext_nibble;
            pend_waddr <= instr_addr + word_ofs;
        end
    end

    // Result registers.
    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid     <= 1'b0;
            res_kind      <= OPK_REG;
            res_reg       <= '0;
            res_value     <= '0;
            res_used_word <= 1'b0;
        end else if (take_word) begin
            res_valid     <= 1'b1;
            res_kind      <= pend_cls.kind;
            res_reg       <= pend_cls.rnum;
            res_value     <= word_value;
            res_used_word <= 1'b1;
        end else if (accept && !cur_needs) begin
            res_valid     <= 1'b1;
            res_kind      <= cur_cls.kind;
            res_reg       <= cur_cls.rnum;
            res_value     <= cur_cls.cval;
            res_used_word <= 1'b0;
        end else begin
            res_valid     <= 1'b0;
        end
    end

endmodule

// File: rtl/opd_checker.sv
module opd_checker (
    input logic        clk,
    input logic        rst,
    input logic        start,
    input logic        is_dst,
    input logic [3:0]  reg_num,
    input logic        word_valid,
    input logic        need_word,
    input logic        word_ready,
    input logic        res_valid,
    input logic [2:0]  res_kind,
    input logic [19:0] res_value,
    input logic        res_used_word
);
    AST_WAIT_HOLDS: assert property (@(posedge clk) disable iff (rst)
        need_word && !word_valid |=> need_word && word_ready); // R10

    AST_WORD_TO_RESULT: assert property (@(posedge clk) disable iff (rst)
        need_word && word_valid |=> res_valid && res_used_word && !need_word); // R10

    AST_CG_NO_FETCH: assert property (@(posedge clk) disable iff (rst)
        start && !need_word && !is_dst && reg_num == 4'd3
        |=> res_valid && res_kind == 3'd1 && !res_used_word); // R2

    AST_PULSE: assert property (@(posedge clk) disable iff (rst)
        res_valid |=> !res_valid); // R11

    AST_POSTINC_ZERO: assert property (@(posedge clk) disable iff (rst)
        res_valid && res_kind == 3'd3 |-> res_value == 20'd0 && !res_used_word); // R8

    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (rst)
        !res_valid && !$rose(res_valid) |=> res_valid || $stable(res_value)); // R11
endmodule

bind opspec_decoder opd_checker u_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .is_dst        (is_dst),
    .reg_num       (reg_num),
    .word_valid    (word_valid),
    .need_word     (need_word),
    .word_ready    (word_ready),
    .res_valid     (res_valid),
    .res_kind      (res_kind),
    .res_value     (res_value),
    .res_used_word (res_used_word)
);

// File: tb/opspec_decoder_test.sv
module opspec_decoder_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        is_dst = 1'b0;
    logic [1:0]  mode = '0;
    logic [3:0]  reg_num = '0;
    logic        ext_active = 1'b0;
    logic [3:0]  ext_nibble = '0;
    logic [19:0] instr_addr = '0;
    logic [19:0] word_ofs = '0;
    logic        word_valid = 1'b0;
    logic [15:0] word_data = '0;
    logic        word_ready, need_word, res_valid, res_used_word;
    logic [2:0]  res_kind;
    logic [3:0]  res_reg;
    logic [19:0] res_value;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    opspec_decoder uut (
        .clk(clk), .rst(rst), .start(start), .is_dst(is_dst), .mode(mode),
        .reg_num(reg_num), .ext_active(ext_active), .ext_nibble(ext_nibble),
        .instr_addr(instr_addr), .word_ofs(word_ofs), .word_valid(word_valid),
        .word_data(word_data), .word_ready(word_ready), .need_word(need_word),
        .res_valid(res_valid), .res_kind(res_kind), .res_reg(res_reg),
        .res_value(res_value), .res_used_word(res_used_word)
    );

    // expected {needs, kind, reg, value}
    function automatic logic [27:0] model(logic d, logic [1:0] m, logic [3:0] r,
            logic x, logic [3:0] nb, logic [19:0] ia, logic [19:0] wo, logic [15:0] w);
        logic [19:0] full;
        logic [19:0] rel;
        full = {(x ? nb : 4'h0), w};
        rel  = full + ia + wo;
        if (d) begin
            if (!m[0])         return {1'b0, 3'd0, r, 20'd0};
            else if (r == 0)   return {1'b1, 3'd4, 4'd0, rel};
            else if (r == 2)   return {1'b1, 3'd4, 4'd0, full};
            else               return {1'b1, 3'd2, r, full};
        end
        case (m)
            2'd0: if (r == 3) return {1'b0, 3'd1, 4'd0, 20'd0};
                  else        return {1'b0, 3'd0, r, 20'd0};
            2'd1: if (r == 3)      return {1'b0, 3'd1, 4'd0, 20'd1};
                  else if (r == 0) return {1'b1, 3'd4, 4'd0, rel};
                  else if (r == 2) return {1'b1, 3'd4, 4'd0, full};
                  else             return {1'b1, 3'd2, r, full};
            2'd2: if (r == 2)      return {1'b0, 3'd1, 4'd0, 20'd4};
                  else if (r == 3) return {1'b0, 3'd1, 4'd0, 20'd2};
                  else             return {1'b0, 3'd2, r, 20'd0};
            default: if (r == 0)   return {1'b1, 3'd1, 4'd0, full};
                  else if (r == 2) return {1'b0, 3'd1, 4'd0, 20'd8};
                  else if (r == 3) return {1'b0, 3'd1, 4'd0, 20'hFFFFF};
                  else             return {1'b0, 3'd3, r, 20'd0};
        endcase
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic run_one(input string tag, input logic d, input logic [1:0] m,
            input logic [3:0] r, input logic x, input logic [3:0] nb,
            input logic [19:0] ia, input logic [19:0] wo, input logic [15:0] w,
            input int delay, input logic poke);
        logic [27:0] e;
        e = model(d, m, r, x, nb, ia, wo, w);
        @(negedge clk);
        start = 1'b1; is_dst = d; mode = m; reg_num = r;
        ext_active = x; ext_nibble = nb; instr_addr = ia; word_ofs = wo;
        @(negedge clk);
        start = 1'b0;
        if (e[27]) begin
            check({tag, " R10 need_word"}, {30'd0, need_word, word_ready}, 32'd3);
            check({tag, " R10 no early result"}, {31'd0, res_valid}, 32'd0);
            for (int i = 0; i < delay; i++) begin
                if (poke && i == 0) begin
                    start = 1'b1; is_dst = 1'b0; mode = 2'd0; reg_num = 4'd5;
                    ext_active = 1'b0; instr_addr = 20'h12345;
                end
                @(negedge clk);
                start = 1'b0;
                check({tag, " R10 still waiting"}, {30'd0, need_word, res_valid}, 32'd2);
            end
            word_valid = 1'b1; word_data = w;
            @(negedge clk);
            word_valid = 1'b0;
        end
        check({tag, " valid"}, {31'd0, res_valid}, 32'd1);
        check({tag, " kind"}, {29'd0, res_kind}, {29'd0, e[26:24]});
        check({tag, " reg"}, {28'd0, res_reg}, {28'd0, e[23:20]});
        check({tag, " value"}, {12'd0, res_value}, {12'd0, e[19:0]});
        check({tag, " used_word"}, {31'd0, res_used_word}, {31'd0, e[27]});
        @(negedge clk);
        check({tag, " R11 pulse"}, {31'd0, res_valid}, 32'd0);
        check({tag, " R11 hold"}, {12'd0, res_value}, {12'd0, e[19:0]});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : main
        int seed;
        seed = 32'h5eed1;
        void'($urandom(seed));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check("R1 reset state", {29'd0, res_valid, need_word, word_ready}, 32'd0);

        // R2 constant generator register
        for (int m = 0; m < 4; m++)
            run_one("R2 cg", 1'b0, 2'(m), 4'd3, 1'b1, 4'hA, 20'h100, 20'd2, 16'h0, 0, 1'b0);
        // R3 status register
        for (int m = 0; m < 4; m += 2)
            run_one("R3 sr", 1'b0, 2'(m), 4'd2, 1'b0, 4'h0, 20'h0, 20'd2, 16'h0, 0, 1'b0);
        run_one("R3 sr m3", 1'b0, 2'd3, 4'd2, 1'b0, 4'h0, 20'h0, 20'd2, 16'h0, 0, 1'b0);
        // R4 destination register mode, all registers
        for (int r = 0; r < 16; r++)
            run_one("R4 dst reg", 1'b1, 2'd2, 4'(r), 1'b0, 4'h0, 20'h0, 20'd2, 16'h0, 0, 1'b0);
        // R5 symbolic with wrap
        run_one("R5 sym wrap", 1'b0, 2'd1, 4'd0, 1'b1, 4'hF, 20'hFFFF0, 20'd4, 16'hFFFF, 2, 1'b0);
        run_one("R5 dst sym", 1'b1, 2'd1, 4'd0, 1'b0, 4'h7, 20'h01000, 20'd2, 16'h0010, 0, 1'b0);
        // R6 absolute
        run_one("R6 abs", 1'b1, 2'd1, 4'd2, 1'b1, 4'h3, 20'h0, 20'd4, 16'hBEEF, 1, 1'b0);
        // R7 indexed
        run_one("R7 idx", 1'b0, 2'd1, 4'd9, 1'b0, 4'h5, 20'h0, 20'd2, 16'h8001, 0, 1'b0);
        // R8 immediate, postinc, indirect
        run_one("R8 imm", 1'b0, 2'd3, 4'd0, 1'b0, 4'h9, 20'h0, 20'd2, 16'h1234, 0, 1'b0);
        run_one("R8 postinc", 1'b0, 2'd3, 4'd7, 1'b0, 4'h0, 20'h0, 20'd2, 16'h0, 0, 1'b0);
        run_one("R8 ind", 1'b0, 2'd2, 4'd0, 1'b0, 4'h0, 20'h0, 20'd2, 16'h0, 0, 1'b0);
        // R9 extension nibble on immediate
        run_one("R9 ext imm", 1'b0, 2'd3, 4'd0, 1'b1, 4'hC, 20'h0, 20'd2, 16'h5678, 0, 1'b0);
        // R10 start while waiting is ignored
        run_one("R10 busy poke", 1'b0, 2'd1, 4'd6, 1'b1, 4'h2, 20'h00400, 20'd2, 16'h4444, 3, 1'b1);

        // random stream
        for (int k = 0; k < 300; k++) begin
            run_one("RAND R2..R9", 1'($urandom), 2'($urandom), 4'($urandom), 1'($urandom),
                    4'($urandom), 20'($urandom), 20'($urandom_range(0, 6) * 2),
                    16'($urandom), int'($urandom_range(0, 4)), 1'($urandom));
        end

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule